// File: doc/BRIEF.md
# ECC Single-Bit Corrector

This block decides what to do with one 512-byte chunk of flash data after a read. It takes two 3-byte parity codes: the one stored in the spare area and the one computed from the data as it streamed in. From these it reports one of four outcomes. The chunk may be clean. It may hold one flipped data bit, which the block locates. The stored code itself may be damaged. Or the chunk may be beyond repair. A freshly erased chunk, whose stored code reads as all ones and whose computed code is all zeros, counts as clean.

For a single-bit data error the block gives the byte offset (0 to 511) and the bit index (0 to 7). When the fix-up path is built in, it also repairs the byte. It reads the byte over a synchronous byte memory port, then writes it back with that bit inverted. A new chunk is refused only in the one cycle in which the repair read is in flight.

Each 24-bit code is packed as three bytes: bits 7:0 are byte 0, bits 15:8 are byte 1 and bits 23:16 are byte 2. Both codes are inverted and XORed together. The difference is then arranged into a 24-bit syndrome as 12 even/odd pairs, and the block counts its set bits.

Top module: `ecc_corrector`

## Requirements
- R1: When the stored and computed codes are equal, the result status is 0 (clean), with offset 0 and bit 0.
- R2: A request is accepted on a rising edge where `req_valid` and `chk_ready` are both high. `res_valid` is high for exactly the following cycle and carries that request's result. It is low in every other cycle.
- R3: A syndrome with exactly one set bit gives status 2 (damaged check code), and the data is left alone. The syndrome is built from the byte-wise XOR d of the two codes: bits 5:0 take d byte 2 bits 7:2, bits 13:6 take d byte 0, bits 21:14 take d byte 1, and bits 23:22 take d byte 2 bits 1:0.
- R4: The syndrome is correctable when it has exactly 12 set bits and each pair (2k, 2k+1) holds exactly one set bit. A correctable syndrome gives status 1. The bit index is {syn[5], syn[3], syn[1]}, and the byte offset is {syn[23], syn[21], ..., syn[9], syn[7]}.
- R5: A stored code of FFFFFF with a computed code of 000000 gives status 0. A stored code of FFFFFF with any other computed code is decoded as in R1, R3, R4 and R6.
- R6: Every other syndrome gives status 3 (uncorrectable). This includes 12 set bits with a pair that has both bits or neither bit set.
- R7: Offset and bit index are 0 whenever the status is not 1.
- R8: On status 1, `mem_rd_en` is high in the result cycle with `mem_addr` equal to the offset. In the next cycle `mem_wr_en` is high at the same address, and `mem_wr_data` is the returned byte with the indicated bit inverted. Read and write never share a cycle.
- R9: Outcomes other than status 1 cause no memory read or write.
- R10: `chk_ready` is low in the result cycle of a correctable chunk, and a request presented then is dropped. It is high in the write-back cycle, and a request presented there is accepted.
- R11: While reset is held, `res_valid`, `mem_rd_en`, `mem_wr_en` and the status are 0, and `chk_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Codes for one chunk are present |
| stored_ecc | input | 24 | Code read from the spare area |
| calc_ecc | input | 24 | Code computed over the data |
| chk_ready | output | 1 | A request is accepted this cycle |
| res_valid | output | 1 | Result fields are valid this cycle |
| res_status | output | 2 | 0 clean, 1 fixed, 2 code damaged, 3 uncorrectable |
| fix_offset | output | 9 | Byte offset of the bad bit |
| fix_bit | output | 3 | Bit index within that byte |
| mem_rd_en | output | 1 | Repair read of the chunk buffer |
| mem_wr_en | output | 1 | Repair write of the chunk buffer |
| mem_addr | output | 9 | Byte address for the repair access |
| mem_rd_data | input | 8 | Byte returned one cycle after a read |
| mem_wr_data | output | 8 | Repaired byte |

## Verification
Two things can fall in the same cycle: the write-back of one repair and the acceptance of the next chunk. The bench makes this happen by presenting a new request in the first cycle where `chk_ready` returns after a correctable result. In that cycle it compares the write port with a byte image it keeps itself. Some of these back-to-back requests repair the same byte twice, so a read that overtook the earlier write would leave the bit wrong. The final comparison of the whole buffer catches that.

// File: rtl/ecc_pkg.sv
// ecc_pkg: shared sizes and outcome codes for the single-bit ECC corrector.
// Assumes a code built from even/odd parity pairs over one chunk.
package ecc_pkg;
    localparam int PAIRS  = 12;                 // even/odd parity pairs
    localparam int SYN_W  = 2 * PAIRS;          // syndrome width
    localparam int BYTE_W = 8;
    localparam int ECC_W  = 3 * BYTE_W;         // packed code width
    localparam int BIT_W  = 3;                  // bit-in-byte index width
    localparam int OFF_W  = PAIRS - BIT_W;      // byte offset width
    localparam int CNT_W  = $clog2(SYN_W + 1);  // population count width

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_FIXED  = 2'd1,
        ST_ECCBAD = 2'd2,
        ST_FATAL  = 2'd3
    } ecc_status_e;
endpackage

// File: rtl/ecc_syndrome.sv
// ecc_syndrome: inverts both codes, XORs them and arranges the difference
// into pair order. Also flags exact equality and the erased-chunk pattern.
// Assumes byte 0 in bits 7:0 of each packed code. Purely combinational.
module ecc_syndrome
    import ecc_pkg::*;
(
    input  logic [ECC_W-1:0] stored,
    input  logic [ECC_W-1:0] calc,
    output logic [SYN_W-1:0] syn,
    output logic             same,
    output logic             erased
);
    logic [ECC_W-1:0]  diff;
    logic [BYTE_W-1:0] d0, d1, d2;

    // Difference of the complemented codes, split into bytes.
    always_comb begin
        diff = (~stored) ^ (~calc);
        d0   = diff[0*BYTE_W +: BYTE_W];
        d1   = diff[1*BYTE_W +: BYTE_W];
        d2   = diff[2*BYTE_W +: BYTE_W];
    end

    // Pair-ordered syndrome: byte2 high six, byte0, byte1, byte2 low two.
    assign syn    = {d2[1:0], d1, d0, d2[BYTE_W-1:2]};

    // Skip and erased-chunk detection on the raw codes.
    assign same   = (stored == calc);
    assign erased = (&stored) & ~(|calc);
endmodule

// File: rtl/ecc_popcount.sv
// ecc_popcount: counts set bits of a vector. Combinational adder chain;
// assumes W small enough that a linear sum meets timing.
module ecc_popcount #(
    parameter int W   = 24,
    parameter int C_W = $clog2(W + 1)
) (
    input  logic [W-1:0]   vec,
    output logic [C_W-1:0] cnt
);
    // Accumulate the ones of the vector.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++)
            cnt = cnt + C_W'(vec[i]);
    end
endmodule

// File: rtl/ecc_locate.sv
// ecc_locate: takes the odd member of each syndrome pair as one address bit
// and checks that every pair has exactly one member set.
// Low BIT_W pairs give the bit index; the rest give the byte offset.
module ecc_locate
    import ecc_pkg::*;
(
    input  logic [SYN_W-1:0] syn,
    output logic             pairs_ok,
    output logic [OFF_W-1:0] offset,
    output logic [BIT_W-1:0] bit_idx
);
    logic [PAIRS-1:0] odd_bits;
    logic [PAIRS-1:0] pair_one;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        // Odd member carries the address bit; the pair must differ.
        assign odd_bits[k] = syn[2*k+1];
        assign pair_one[k] = syn[2*k] ^ syn[2*k+1];
    end

    assign pairs_ok = &pair_one;
    assign bit_idx  = odd_bits[BIT_W-1:0];
    assign offset   = odd_bits[PAIRS-1:BIT_W];
endmodule

// File: rtl/ecc_fix_rmw.sv
// ecc_fix_rmw: two-phase read-modify-write that inverts one bit of one byte.
// Assumes a memory whose read data comes back one cycle after the read and
// which takes a write on the edge that ends the write cycle.
module ecc_fix_rmw #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 9,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [IDX_W-1:0]  bit_in,
    output logic              busy,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [DATA_W-1:0] mem_wr_data
);
    logic              ph_rd, ph_wr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] mask_q;

    // Phase sequencer and capture of target address and flip mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_rd  <= 1'b0;
            ph_wr  <= 1'b0;
            addr_q <= '0;
            mask_q <= '0;
        end else begin
            ph_rd <= start;
            ph_wr <= ph_rd;
            if (start) begin
                addr_q <= addr_in;
                mask_q <= DATA_W'(1) << bit_in;
            end
        end
    end

    assign busy        = ph_rd;
    assign mem_rd_en   = ph_rd;
    assign mem_wr_en   = ph_wr;
    assign mem_addr    = addr_q;
    assign mem_wr_data = mem_rd_data ^ mask_q;
endmodule

// File: rtl/ecc_corrector.sv
// ecc_corrector: classifies a stored/computed code pair for one chunk and
// optionally repairs a single flipped data bit in the chunk buffer.
// Result registered one cycle after acceptance; synchronous active-low reset.
module ecc_corrector
    import ecc_pkg::*;
#(
    parameter bit APPLY_FIX = 1'b1,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ECC_W-1:0]  stored_ecc,
    input  logic [ECC_W-1:0]  calc_ecc,
    output logic              chk_ready,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [OFF_W-1:0]  fix_offset,
    output logic [BIT_W-1:0]  fix_bit,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [OFF_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [DATA_W-1:0] mem_wr_data
);
    logic [SYN_W-1:0] syn;
    logic             same, erased, pairs_ok, busy, accept;
    logic [CNT_W-1:0] ones;
    logic [OFF_W-1:0] loc_off;
    logic [BIT_W-1:0] loc_bit;
    ecc_status_e      nxt_st;

    ecc_syndrome u_syn (.stored(stored_ecc), .calc(calc_ecc),
                        .syn(syn), .same(same), .erased(erased));

    ecc_popcount #(.W(SYN_W), .C_W(CNT_W)) u_cnt (.vec(syn), .cnt(ones));

    ecc_locate u_loc (.syn(syn), .pairs_ok(pairs_ok),
                      .offset(loc_off), .bit_idx(loc_bit));

    // Outcome selection in priority order.
    always_comb begin
        if (same || erased)
            nxt_st = ST_CLEAN;
        else if (ones == CNT_W'(1))
            nxt_st = ST_ECCBAD;
        else if (ones == CNT_W'(PAIRS) && pairs_ok)
            nxt_st = ST_FIXED;
        else
            nxt_st = ST_FATAL;
    end

    assign chk_ready = ~busy;
    assign accept    = req_valid & chk_ready;

    // Result register: pulse valid, hold fields until the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_status <= ST_CLEAN;
            fix_offset <= '0;
            fix_bit    <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_status <= nxt_st;
                fix_offset <= (nxt_st == ST_FIXED) ? loc_off : '0;
                fix_bit    <= (nxt_st == ST_FIXED) ? loc_bit : '0;
            end
        end
    end

    if (APPLY_FIX) begin : g_fix
        ecc_fix_rmw #(.DATA_W(DATA_W), .ADDR_W(OFF_W), .IDX_W(BIT_W)) u_rmw (
            .clk(clk), .rst_n(rst_n),
            .start(accept && nxt_st == ST_FIXED),
            .addr_in(loc_off), .bit_in(loc_bit), .busy(busy),
            .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
            .mem_rd_data(mem_rd_data), .mem_wr_data(mem_wr_data));
    end else begin : g_nofix
        assign busy        = 1'b0;
        assign mem_rd_en   = 1'b0;
        assign mem_wr_en   = 1'b0;
        assign mem_addr    = '0;
        assign mem_wr_data = mem_rd_data & '0;
    end
endmodule

// File: rtl/ecc_corrector_chk.sv
// ecc_corrector_chk: temporal checks on the corrector's ports, bound below.
module ecc_corrector_chk
    import ecc_pkg::*;
#(
    parameter bit APPLY_FIX = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             chk_ready,
    input logic             res_valid,
    input logic [1:0]       res_status,
    input logic [OFF_W-1:0] fix_offset,
    input logic [BIT_W-1:0] fix_bit,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic [OFF_W-1:0] mem_addr
);
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_ready) |=> res_valid);
    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && chk_ready) |=> !res_valid);
    assert_location_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status != ST_FIXED) |-> (fix_offset == '0 && fix_bit == '0));
    assert_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (res_valid && res_status == ST_FIXED));
    assert_busy_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_ready |=> !res_valid);
    assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_wr_en}));

    if (APPLY_FIX) begin : g_fixchk
        assert_read_on_fix_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && res_status == ST_FIXED) |-> (mem_rd_en && mem_addr == fix_offset));
        assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));
    end
endmodule

bind ecc_corrector ecc_corrector_chk #(.APPLY_FIX(APPLY_FIX)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .chk_ready(chk_ready),
    .res_valid(res_valid), .res_status(res_status), .fix_offset(fix_offset),
    .fix_bit(fix_bit), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr));

// File: tb/ecc_corrector_tb.sv
`timescale 1ns/1ps
module ecc_corrector_tb;
    import ecc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] stored_ecc = '0, calc_ecc = '0;
    logic        chk_ready, res_valid, mem_rd_en, mem_wr_en;
    logic [1:0]  res_status;
    logic [8:0]  fix_offset, mem_addr;
    logic [2:0]  fix_bit;
    logic [7:0]  mem_rd_data = '0, mem_wr_data;

    always #2.5 clk = ~clk;

    ecc_corrector #(.APPLY_FIX(1'b1), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .stored_ecc(stored_ecc), .calc_ecc(calc_ecc), .chk_ready(chk_ready),
        .res_valid(res_valid), .res_status(res_status), .fix_offset(fix_offset),
        .fix_bit(fix_bit), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .mem_wr_data(mem_wr_data));

    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];
    int nvec = 0, nmis = 0, nwr = 0, nwr_exp = 0;
    bit pend = 0;
    logic [8:0] pend_a;
    logic [7:0] pend_d;

    // Chunk buffer model: one-cycle read latency, write on the edge.
    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wr_data;
            nwr <= nwr + 1;
        end
        if (mem_rd_en) mem_rd_data <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nvec++;
        if (!ok) begin
            nmis++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected outcome from the requirement text (R1, R3..R7).
    task automatic exp_decode(input logic [23:0] s, input logic [23:0] c,
                              output logic [1:0] st, output logic [8:0] off,
                              output logic [2:0] b);
        logic [23:0] d, syn;
        bit ok;
        d   = s ^ c;
        syn = {d[17:16], d[15:8], d[7:0], d[23:18]};
        ok  = 1;
        for (int k = 0; k < 12; k++) if (syn[2*k] == syn[2*k+1]) ok = 0;
        off = '0; b = '0;
        if (s == c || (s == 24'hFFFFFF && c == 24'h0)) st = 2'd0;
        else if ($countones(syn) == 1) st = 2'd2;
        else if ($countones(syn) == 12 && ok) begin
            st = 2'd1;
            b  = {syn[5], syn[3], syn[1]};
            for (int k = 0; k < 9; k++) off[k] = syn[7 + 2*k];
        end else st = 2'd3;
    endtask

    // Difference vector that produces a given syndrome (R3 mapping).
    function automatic logic [23:0] syn2diff(input logic [23:0] syn);
        logic [7:0] x0, x1, x2;
        x0 = syn[13:6];
        x1 = syn[21:14];
        x2 = {syn[5:0], syn[23:22]};
        return {x2, x1, x0};
    endfunction

    // Syndrome of a single data-bit error at (off, b) per R4.
    function automatic logic [23:0] make_single(input logic [8:0] off, input logic [2:0] b);
        logic [23:0] syn = '0;
        for (int k = 0; k < 12; k++) begin
            logic a;
            a = (k < 3) ? b[k] : off[k-3];
            syn[2*k + a] = 1'b1;
        end
        return syn;
    endfunction

    // Checks the write-back port in the cycle after a repair read.
    task automatic check_pending();
        if (pend) begin
            chk(mem_wr_en === 1'b1, "R8", "wr_en", int'(mem_wr_en), 1);
            chk(mem_addr == pend_a, "R8", "wr_addr", int'(mem_addr), int'(pend_a));
            chk(mem_wr_data == pend_d, "R8", "wr_data", int'(mem_wr_data), int'(pend_d));
            pend = 0;
        end else
            chk(mem_wr_en === 1'b0, "R9", "idle wr_en", int'(mem_wr_en), 0);
    endtask

    task automatic run(input logic [23:0] s, input logic [23:0] c);
        logic [1:0] st;
        logic [8:0] off;
        logic [2:0] b;
        string tag;
        @(negedge clk);
        check_pending();
        while (!chk_ready) @(negedge clk);
        stored_ecc = s; calc_ecc = c; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        exp_decode(s, c, st, off, b);
        if (s == 24'hFFFFFF && c == 24'h0) tag = "R5";
        else case (st)
            2'd0: tag = "R1";
            2'd1: tag = "R4";
            2'd2: tag = "R3";
            default: tag = "R6";
        endcase
        chk(res_valid === 1'b1, "R2", "res_valid", int'(res_valid), 1);
        chk(res_status == st, tag, "status", int'(res_status), int'(st));
        chk(fix_offset == off, (st == 2'd1) ? "R4" : "R7", "offset", int'(fix_offset), int'(off));
        chk(fix_bit == b, (st == 2'd1) ? "R4" : "R7", "bit", int'(fix_bit), int'(b));
        if (st == 2'd1) begin
            chk(mem_rd_en === 1'b1 && mem_addr == off, "R8", "read addr", int'(mem_addr), int'(off));
            chk(chk_ready === 1'b0, "R10", "ready in read cycle", int'(chk_ready), 0);
            pend   = 1;
            pend_a = off;
            pend_d = exp_mem[off] ^ (8'd1 << b);
            exp_mem[off] = pend_d;
            nwr_exp++;
        end else
            chk(mem_rd_en === 1'b0, "R9", "rd_en", int'(mem_rd_en), 0);
    endtask

    // Presents a request while ready is low; it must be dropped.
    task automatic poke_busy();
        stored_ecc = 24'h123456; calc_ecc = 24'h123456; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_pending();
        chk(res_valid === 1'b0, "R10", "dropped request", int'(res_valid), 0);
        @(negedge clk);
        chk(res_valid === 1'b0, "R10", "dropped request later", int'(res_valid), 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    endtask

    initial begin
        #(5.0 * 150000);
        nmis++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 512; i++) begin
            mem[i]     = 8'(i * 37 + 11);
            exp_mem[i] = 8'(i * 37 + 11);
        end
        repeat (3) @(negedge clk);
        chk(res_valid === 1'b0, "R11", "res_valid", int'(res_valid), 0);
        chk(chk_ready === 1'b1, "R11", "chk_ready", int'(chk_ready), 1);
        chk(mem_rd_en === 1'b0 && mem_wr_en === 1'b0, "R11", "mem ctrl",
            int'({mem_rd_en, mem_wr_en}), 0);
        chk(res_status == 2'd0, "R11", "status", int'(res_status), 0);
        rst_n = 1'b1;

        // Directed corner cases.
        run(24'hA5C33C, 24'hA5C33C);                                   // R1
        run(24'hFFFFFF, 24'h000000);                                   // R5 erased
        run(24'hFFFFFF, 24'h000001);                                   // R5 decoded
        run(24'h0F0F0F ^ syn2diff(make_single(9'd0, 3'd0)), 24'h0F0F0F);   // R4 low
        run(24'h0F0F0F ^ syn2diff(make_single(9'd511, 3'd7)), 24'h0F0F0F); // R4 high
        run(24'h0F0F0F ^ syn2diff(make_single(9'd511, 3'd0)), 24'h0F0F0F); // same byte, R10
        run(24'h000000 ^ syn2diff(24'h800000), 24'h000000);            // R3 top bit
        run(24'h777777 ^ syn2diff(24'h000001), 24'h777777);            // R3 bottom bit
        run(24'h135790 ^ syn2diff(24'h000FFF), 24'h135790);            // R6 broken pairs
        run(24'h000000, 24'hFFFFFF);                                   // R6 all differ
        run(24'h222222 ^ syn2diff(make_single(9'd77, 3'd5)), 24'h222222);  // R10 poke
        poke_busy();

        // Constrained random mix.
        for (int n = 0; n < 400; n++) begin
            logic [23:0] c, s;
            c = 24'($urandom());
            case ($urandom_range(0, 4))
                0: s = c;
                1: s = c ^ syn2diff(make_single(9'($urandom()), 3'($urandom())));
                2: s = c ^ (24'd1 << $urandom_range(0, 23));
                3: s = c ^ 24'($urandom());
                default: begin
                    s = 24'hFFFFFF;
                    if ($urandom_range(0, 1) == 0) c = 24'h0;
                end
            endcase
            run(s, c);
        end

        @(negedge clk);
        check_pending();
        repeat (3) @(negedge clk);
        begin
            int bad = 0;
            for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
            chk(bad == 0, "R8", "buffer bytes wrong", bad, 0);
        end
        chk(nwr == nwr_exp, "R9", "write count", nwr, nwr_exp);
        summary();
        $finish;
    end
endmodule